// File: doc/BRIEF.md
# Effective memory-access privilege resolver

This block sits beside the load/store unit of a RISC-V core that implements the hypervisor extension. For every memory access it works out three things: the privilege level that translation and permission checks must use, whether the access goes through two-stage (guest) translation, and whether a hypervisor virtual-machine load or store may execute at all. It also tracks whether such a hypervisor access is in flight.

The core raises `hls_start` for one cycle when it decodes a hypervisor load or store, with `hls_exec` set for the execute-checked load variant. If the access is permitted, an in-flight flag rises on the next clock edge and stays up until `hls_done` or `trap_entry`. While that flag is up, the access privilege comes from the supervisor-previous-virtual-privilege bit and the machine-mode privilege-modify bit (MPRV) has no effect. A rejected request raises `illegal_instr` in the same cycle and leaves the flag clear. All pins are plain level or strobe controls. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `hvm_priv_resolver`

## Requirements
- R1: Privilege is encoded as U=2'b00, S=2'b01, M=2'b11. Access kind is encoded as fetch=2'b00, load=2'b01, store=2'b10. With no hypervisor access in flight, `eff_priv` equals `cur_priv` unless R2 applies.
- R2: With no hypervisor access in flight, when `cur_priv` is M, the access is not a fetch and `mprv` is 1, `eff_priv` equals `mpp`.
- R3: With no hypervisor access in flight, `two_stage_en` is 1 exactly when the extension is present, `cur_priv` is M, the access is not a fetch, `mprv` is 1 and `mpv` is 1.
- R4: A permitted `hls_start` sets `hls_busy` from the next cycle on. While `hls_busy` is 1, `two_stage_en` is 1 and `eff_priv` is {1'b0, `spvp`}, whatever `mprv`, `mpp` and `cur_priv` are.
- R5: `hls_start` is permitted in M mode, in S mode with `cur_virt`=0, and in U mode with `cur_virt`=0 and `hu`=1. It is rejected in every other case, including the reserved privilege value 2'b10.
- R6: A rejected `hls_start` drives `illegal_instr` to 1 in that same cycle and leaves `hls_busy` at 0. `illegal_instr` is 0 in any cycle without `hls_start`.
- R7: `hls_busy` is 0 after reset. `hls_done` clears it on the next edge, unless a permitted `hls_start` arrives in the same cycle, in which case the flag stays set.
- R8: `trap_entry` clears `hls_busy` on the next edge and wins over a same-cycle `hls_start` or `hls_done`.
- R9: `exec_perm` is 1 exactly while `hls_busy` is 1 for an access that was started with `hls_exec`=1.
- R10: Built with `HAS_HEXT`=0, `hls_busy`, `exec_perm` and `two_stage_en` stay 0, and every `hls_start` is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Virtualization mode active |
| acc_kind | input | 2 | Kind of the current access |
| mprv | input | 1 | Machine privilege-modify enable |
| mpp | input | 2 | Machine previous privilege |
| mpv | input | 1 | Machine previous virtualization mode |
| spvp | input | 1 | Privilege used by hypervisor guest accesses |
| hu | input | 1 | Allows hypervisor accesses from U mode |
| hls_start | input | 1 | Decoded hypervisor load/store, one-cycle strobe |
| hls_exec | input | 1 | Started access checks execute rights instead of read rights |
| hls_done | input | 1 | Hypervisor access completes |
| trap_entry | input | 1 | Trap taken this cycle |
| eff_priv | output | 2 | Privilege used for translation and checks |
| two_stage_en | output | 1 | Two-stage translation applies |
| illegal_instr | output | 1 | Hypervisor access rejected |
| hls_busy | output | 1 | Hypervisor access in flight |
| exec_perm | output | 1 | In-flight access uses execute permission |

## Verification
The only internal state is the in-flight flag and its execute-check companion. A wrong value in either one shows at the ports on the very next cycle: `eff_priv` would follow `mpp` or `cur_priv` instead of `spvp`, `two_stage_en` would drop, and `exec_perm` would disagree. The bench therefore compares every output on every clock against a behavioural model. Trap and start collisions and done-with-start overlaps are driven on purpose, because a priority mistake there leaves a stale flag that is visible one cycle later. A second instance built without the extension confirms that the flag can never be set.

// File: rtl/hvm_priv_pkg.sv
package hvm_priv_pkg;
  localparam int PRIV_W = 2;
  localparam int KIND_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10
  } kind_e;
endpackage

// File: rtl/hvm_access_gate.sv
module hvm_access_gate
  import hvm_priv_pkg::*;
#(
  parameter bit HAS_HEXT = 1'b1
) (
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              cur_virt,
  input  logic              hu,
  input  logic              hls_start,
  output logic              start_ok,
  output logic              illegal
);
  logic mode_allows;

  // Decide whether the current mode may issue a guest load/store.
  always_comb begin
    unique case (cur_priv)
      PRIV_M:  mode_allows = 1'b1;
      PRIV_S:  mode_allows = !cur_virt;
      PRIV_U:  mode_allows = !cur_virt && hu;
      default: mode_allows = 1'b0;
    endcase
  end

  assign start_ok = hls_start && mode_allows && HAS_HEXT;
  assign illegal  = hls_start && !start_ok;
endmodule

// File: rtl/hvm_flight_track.sv
module hvm_flight_track #(
  parameter bit HAS_HEXT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic start_exec,
  input  logic done,
  input  logic trap,
  output logic busy,
  output logic busy_exec
);
  generate
    if (HAS_HEXT) begin : g_track
      logic busy_q, exec_q;

      // Priority: trap clears, then a new start sets, then completion clears.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q <= 1'b0;
          exec_q <= 1'b0;
        end else if (trap) begin
          busy_q <= 1'b0;
          exec_q <= 1'b0;
        end else if (start_ok) begin
          busy_q <= 1'b1;
          exec_q <= start_exec;
        end else if (done) begin
          busy_q <= 1'b0;
          exec_q <= 1'b0;
        end
      end

      assign busy      = busy_q;
      assign busy_exec = busy_q && exec_q;
    end else begin : g_none
      logic unused_track;
      assign unused_track = &{1'b0, clk, rst_n, start_ok, start_exec, done, trap};
      assign busy      = 1'b0;
      assign busy_exec = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hvm_priv_select.sv
module hvm_priv_select
  import hvm_priv_pkg::*;
#(
  parameter bit HAS_HEXT = 1'b1
) (
  input  logic              busy,
  input  logic              spvp,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic              mprv,
  input  logic [PRIV_W-1:0] mpp,
  input  logic              mpv,
  output logic [PRIV_W-1:0] eff_priv,
  output logic              two_stage
);
  logic modify_path;

  assign modify_path = (cur_priv == PRIV_M) && (acc_kind != KIND_FETCH) && mprv;

  always_comb begin
    if (busy) begin
      // Guest accesses take their privilege from spvp and ignore mprv.
      eff_priv  = {{(PRIV_W-1){1'b0}}, spvp};
      two_stage = 1'b1;
    end else begin
      eff_priv  = modify_path ? mpp : cur_priv;
      two_stage = HAS_HEXT && modify_path && mpv;
    end
  end
endmodule

// File: rtl/hvm_priv_resolver.sv
module hvm_priv_resolver
  import hvm_priv_pkg::*;
#(
  parameter bit HAS_HEXT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic [1:0] acc_kind,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       mpv,
  input  logic       spvp,
  input  logic       hu,
  input  logic       hls_start,
  input  logic       hls_exec,
  input  logic       hls_done,
  input  logic       trap_entry,
  output logic [1:0] eff_priv,
  output logic       two_stage_en,
  output logic       illegal_instr,
  output logic       hls_busy,
  output logic       exec_perm
);
  logic start_ok;

  hvm_access_gate #(.HAS_HEXT(HAS_HEXT)) gate_i (
    .cur_priv (cur_priv),
    .cur_virt (cur_virt),
    .hu       (hu),
    .hls_start(hls_start),
    .start_ok (start_ok),
    .illegal  (illegal_instr)
  );

  hvm_flight_track #(.HAS_HEXT(HAS_HEXT)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .start_exec(hls_exec),
    .done      (hls_done),
    .trap      (trap_entry),
    .busy      (hls_busy),
    .busy_exec (exec_perm)
  );

  hvm_priv_select #(.HAS_HEXT(HAS_HEXT)) sel_i (
    .busy     (hls_busy),
    .spvp     (spvp),
    .cur_priv (cur_priv),
    .acc_kind (acc_kind),
    .mprv     (mprv),
    .mpp      (mpp),
    .mpv      (mpv),
    .eff_priv (eff_priv),
    .two_stage(two_stage_en)
  );
endmodule

// File: rtl/hvm_priv_resolver_chk.sv
module hvm_priv_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spvp,
  input logic       hls_start,
  input logic       trap_entry,
  input logic [1:0] eff_priv,
  input logic       two_stage_en,
  input logic       illegal_instr,
  input logic       hls_busy,
  input logic       exec_perm
);
  // R4
  busy_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hls_busy |-> (two_stage_en && eff_priv == {1'b0, spvp}));

  // R8
  trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> !hls_busy);

  // R6
  reject_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_instr && !hls_busy) |=> !hls_busy);

  // R6
  illegal_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_instr |-> hls_start);

  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hls_busy) |-> $past(hls_start));

  // R9
  exec_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_perm |-> hls_busy);
endmodule

bind hvm_priv_resolver hvm_priv_resolver_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .spvp         (spvp),
  .hls_start    (hls_start),
  .trap_entry   (trap_entry),
  .eff_priv     (eff_priv),
  .two_stage_en (two_stage_en),
  .illegal_instr(illegal_instr),
  .hls_busy     (hls_busy),
  .exec_perm    (exec_perm)
);

// File: tb/hvm_priv_resolver_tb_top.sv
module hvm_priv_resolver_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cur_priv = 2'b00, acc_kind = 2'b00, mpp = 2'b00;
  logic cur_virt = 0, mprv = 0, mpv = 0, spvp = 0, hu = 0;
  logic hls_start = 0, hls_exec = 0, hls_done = 0, trap_entry = 0;

  logic [1:0] eff_a, eff_b;
  logic ts_a, ts_b, ill_a, ill_b, busy_a, busy_b, ex_a, ex_b;

  int n_run = 0, n_fail = 0;
  bit m_busy = 0, m_x = 0;

  always #(CLK_P/2) clk = ~clk;

  hvm_priv_resolver #(.HAS_HEXT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .acc_kind(acc_kind), .mprv(mprv), .mpp(mpp), .mpv(mpv), .spvp(spvp),
    .hu(hu), .hls_start(hls_start), .hls_exec(hls_exec), .hls_done(hls_done),
    .trap_entry(trap_entry), .eff_priv(eff_a), .two_stage_en(ts_a),
    .illegal_instr(ill_a), .hls_busy(busy_a), .exec_perm(ex_a));

  hvm_priv_resolver #(.HAS_HEXT(1'b0)) dut_noh (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .acc_kind(acc_kind), .mprv(mprv), .mpp(mpp), .mpv(mpv), .spvp(spvp),
    .hu(hu), .hls_start(hls_start), .hls_exec(hls_exec), .hls_done(hls_done),
    .trap_entry(trap_entry), .eff_priv(eff_b), .two_stage_en(ts_b),
    .illegal_instr(ill_b), .hls_busy(busy_b), .exec_perm(ex_b));

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit allowed();
    return (cur_priv == 2'b11) || (cur_priv == 2'b01 && !cur_virt) ||
           (cur_priv == 2'b00 && !cur_virt && hu);
  endfunction

  function automatic bit mod_on();
    return cur_priv == 2'b11 && acc_kind != 2'b00 && mprv;
  endfunction

  task automatic tick(input string tag);
    int e_priv;
    #(CLK_P/4);
    e_priv = m_busy ? int'(spvp) : (mod_on() ? int'(mpp) : int'(cur_priv));
    check(tag, "eff_priv", eff_a, e_priv);
    check(tag, "two_stage", ts_a, int'(m_busy || (mod_on() && mpv)));
    check(tag, "illegal", ill_a, int'(hls_start && !allowed()));
    check(tag, "busy", busy_a, int'(m_busy));
    check(tag, "exec_perm", ex_a, int'(m_busy && m_x));
    // R10: second build without the extension
    check("R10", "noh_eff", eff_b, mod_on() ? int'(mpp) : int'(cur_priv));
    check("R10", "noh_ts", ts_b, 0);
    check("R10", "noh_ill", ill_b, int'(hls_start));
    check("R10", "noh_busy", busy_b, 0);
    check("R10", "noh_ex", ex_b, 0);
    @(posedge clk);
    if (trap_entry) begin m_busy = 0; m_x = 0; end
    else if (hls_start && allowed()) begin m_busy = 1; m_x = hls_exec; end
    else if (hls_done) begin m_busy = 0; m_x = 0; end
    @(negedge clk);
    hls_start = 0; hls_exec = 0; hls_done = 0; trap_entry = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R7");  // reset state: flag clear
    // R1: plain privilege pass-through
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) begin
        cur_priv = 2'(p); acc_kind = 2'(k); mpp = 2'b01; mprv = (p != 3); mpv = 1;
        tick("R1");
      end
    end
    // R2/R3: MPRV in M mode, fetch versus data
    cur_priv = 2'b11; mprv = 1;
    for (int m = 0; m < 4; m++) begin
      mpp = 2'(m); mpv = m[0];
      acc_kind = 2'b01; tick("R2");
      acc_kind = 2'b10; tick("R3");
      acc_kind = 2'b00; tick("R3");
    end
    // R4: start from M, MPRV ignored while busy
    acc_kind = 2'b01; mpp = 2'b11; mpv = 0; spvp = 1;
    hls_start = 1; tick("R4");
    tick("R4");
    spvp = 0; cur_priv = 2'b00; tick("R4");
    hls_done = 1; tick("R7");
    tick("R7");
    // R5/R6: permission matrix
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 2; v++) begin
        for (int h = 0; h < 2; h++) begin
          cur_priv = 2'(p); cur_virt = v[0]; hu = h[0];
          hls_start = 1; tick("R5");
          tick("R6");
          hls_done = 1; tick("R6");
        end
      end
    end
    cur_virt = 0; cur_priv = 2'b01;
    // R9: execute-checked variant, then a plain restart replaces it
    hls_start = 1; hls_exec = 1; tick("R9");
    tick("R9");
    hls_start = 1; hls_done = 1; tick("R7");  // start beats done
    tick("R9");
    // R8: trap clears; trap beats start and done
    trap_entry = 1; tick("R8");
    tick("R8");
    hls_start = 1; trap_entry = 1; tick("R8");
    tick("R8");
    hls_start = 1; hls_exec = 1; tick("R8");
    trap_entry = 1; hls_done = 1; tick("R8");
    tick("R8");
    // R6: rejected start while S with virtualization on
    cur_virt = 1; hls_start = 1; tick("R6");
    tick("R6");
    finish_run();
  end
endmodule